// File: doc/BRIEF.md
# Parser Program Sequencer With Return Stack

This block is the control unit of a small programmable bitstream parser. Each cycle it receives one already-decoded instruction (its kind, a jump target, an iteration count, a data-memory operand and a branch-mode field) together with two condition bits from the comparators in the functional unit. From these it chooses the next program-memory address. It also drives the data-memory address and the read and write strobes for that same instruction. Every instruction that is not stalled completes in one cycle.

A single eight-entry hardware stack serves three constructs. It holds return addresses for layer calls and for taken branches, and it holds the body start address and remaining count for counted loops. A branch instruction evaluates both condition bits in the same cycle under a mode field. Stack misuse is fatal to the program. A push onto a full stack sets an overflow flag, a pop of an empty stack sets an underflow flag, and either one halts the sequencer until reset. A stall input from the bit extractor freezes the sequencer for as long as it is held.

Top module: `psq_sequencer`

## Requirements
- R1: After reset the program address is 0, the overflow, underflow and halted outputs are low, and the stack is empty.
- R2: Instruction kind codes are 0 fixed-length decode, 1 variable-length decode, 2 layer call, 3 calculate, 4 loop start, 5 branch, 6 loop end, 7 return. A decode (code 0 or 1) asserts the data write strobe with the data address equal to the operand field and no read strobe, and advances the program address by one.
- R3: A calculate (code 3) asserts both the data read and the data write strobes to the operand address in the same cycle, and advances the program address by one.
- R4: A layer call (code 2) pushes the address after the call and jumps to the target. A return (code 7) pops the top entry and resumes at its stored address.
- R5: A loop start (code 4) pushes the address after it together with the count field, then advances. At a loop end (code 6) a stored count above 1 is decremented and the program jumps back to the stored address. Otherwise the entry is popped and execution continues after the loop end, so a count of 0 or 1 runs the body once.
- R6: A branch (code 5) is taken when the mode is 0 and both conditions are set, when the mode is 1 and either is set, or when the mode is 2 or 3 and the first condition is set. A taken branch pushes the address after it and jumps to the target. An untaken branch goes to the next address and pushes nothing.
- R7: A return or a loop end with an empty stack sets the underflow flag and halts, and the program address stays at that instruction.
- R8: A push while all 8 entries are in use sets the overflow flag and halts without changing the program address. This applies to a call, a loop start or a taken branch.
- R9: While stall is high the program address, the stack and the flags hold, and neither data strobe is asserted.
- R10: Once halted, the program address is frozen, both data strobes stay low, program read enable is low, and only reset clears the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freeze request from the bit extractor |
| op | input | 3 | Instruction kind code |
| target | input | AW | Jump target for call and branch |
| count | input | CW | Iteration count for loop start |
| operand | input | DW | Data-memory address for decode and calculate |
| br_mode | input | 2 | Condition combine mode for branch |
| cond_a | input | 1 | First comparator result |
| cond_b | input | 1 | Second comparator result |
| pc | output | AW | Program-memory address |
| pmem_re | output | 1 | Program-memory read enable |
| dmem_addr | output | DW | Data-memory address |
| dmem_we | output | 1 | Data-memory write strobe |
| dmem_re | output | 1 | Data-memory read strobe |
| ovf | output | 1 | Stack overflow flag |
| unf | output | 1 | Stack underflow flag |
| halted | output | 1 | Sequencer halted |

## Verification
The bench covers loop counts of 0, 1 and 3. A loop end that tests for zero instead of above one would run the body one extra time. It drives every branch mode with mixed condition pairs. A wrong combine would jump where it should fall through, and a push on an untaken branch would turn a later empty-stack return into a normal jump. It fills the stack to exactly eight entries and then pushes again, checking that the sequencer halts rather than wrapping. It issues stalled calls and decodes, where a leaky stall shows up as a moved address, a write strobe, or a push that a later return exposes.

// File: rtl/psq_pkg.sv
package psq_pkg;

  typedef enum logic [2:0] {
    OP_FIXDEC  = 3'd0,
    OP_VARDEC  = 3'd1,
    OP_CALL    = 3'd2,
    OP_CALC    = 3'd3,
    OP_LOOP    = 3'd4,
    OP_BRANCH  = 3'd5,
    OP_ENDLOOP = 3'd6,
    OP_RETURN  = 3'd7
  } psq_op_e;

  typedef enum logic [1:0] {
    BM_AND   = 2'd0,
    BM_OR    = 2'd1,
    BM_FIRST = 2'd2,
    BM_FIRST2 = 2'd3
  } psq_bmode_e;

  // Combine the two comparator results under the branch mode.
  function automatic logic branch_taken(input logic [1:0] mode, input logic a, input logic b);
    logic t;
    case (psq_bmode_e'(mode))
      BM_AND:  t = a & b;
      BM_OR:   t = a | b;
      default: t = a;
    endcase
    return t;
  endfunction

  // A loop entry repeats while more than one pass remains.
  function automatic logic loop_again(input int unsigned remaining);
    return remaining > 1;
  endfunction

  function automatic logic op_writes_data(input psq_op_e o);
    return (o == OP_FIXDEC) || (o == OP_VARDEC) || (o == OP_CALC);
  endfunction

  function automatic logic op_reads_data(input psq_op_e o);
    return o == OP_CALC;
  endfunction

  function automatic logic op_pushes(input psq_op_e o, input logic taken);
    return (o == OP_CALL) || (o == OP_LOOP) || ((o == OP_BRANCH) && taken);
  endfunction

  function automatic logic op_pops(input psq_op_e o);
    return (o == OP_ENDLOOP) || (o == OP_RETURN);
  endfunction

endpackage

// File: rtl/psq_stack.sv
module psq_stack #(
  parameter int DEPTH = 8,
  parameter int AW    = 10,
  parameter int CW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [CW-1:0] push_cnt,
  input  logic          pop,
  input  logic          dec_top,
  output logic [AW-1:0] top_addr,
  output logic [CW-1:0] top_cnt,
  output logic          full,
  output logic          empty
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LW-1:0] sp_q;
  logic [AW-1:0] addr_q [DEPTH];
  logic [CW-1:0] cnt_q  [DEPTH];
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] top_idx;
  logic          do_push;
  logic          do_pop;
  logic          do_dec;

  assign full    = (sp_q == LW'(DEPTH));
  assign empty   = (sp_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign do_dec  = dec_top & ~empty;
  assign wr_idx  = IW'(sp_q);
  assign top_idx = IW'(sp_q - LW'(1));

  assign top_addr = empty ? '0 : addr_q[top_idx];
  assign top_cnt  = empty ? '0 : cnt_q[top_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (do_push) begin
      sp_q <= sp_q + LW'(1);
    end else if (do_pop) begin
      sp_q <= sp_q - LW'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic load_g;
    logic dec_g;
    assign load_g = do_push && (wr_idx == IW'(g));
    assign dec_g  = do_dec && !do_push && (top_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q[g] <= '0;
        cnt_q[g]  <= '0;
      end else if (load_g) begin
        addr_q[g] <= push_addr;
        cnt_q[g]  <= push_cnt;
      end else if (dec_g) begin
        cnt_q[g] <= cnt_q[g] - CW'(1);
      end
    end
  end

endmodule

// File: rtl/psq_cond_unit.sv
module psq_cond_unit (
  input  logic [1:0] mode,
  input  logic       cond_a,
  input  logic       cond_b,
  output logic       taken
);
  assign taken = psq_pkg::branch_taken(mode, cond_a, cond_b);
endmodule

// File: rtl/psq_data_port.sv
module psq_data_port #(
  parameter int DW = 8
) (
  input  logic          active,
  input  logic [2:0]    op,
  input  logic [DW-1:0] operand,
  output logic [DW-1:0] dmem_addr,
  output logic          dmem_we,
  output logic          dmem_re
);
  import psq_pkg::*;

  psq_op_e kind;
  logic    touches;

  assign kind      = psq_op_e'(op);
  assign touches   = active && op_writes_data(kind);
  assign dmem_we   = touches;
  assign dmem_re   = active && op_reads_data(kind);
  assign dmem_addr = touches ? operand : '0;
endmodule

// File: rtl/psq_sequencer.sv
module psq_sequencer #(
  parameter int AW    = 10,
  parameter int CW    = 8,
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic [2:0]    op,
  input  logic [AW-1:0] target,
  input  logic [CW-1:0] count,
  input  logic [DW-1:0] operand,
  input  logic [1:0]    br_mode,
  input  logic          cond_a,
  input  logic          cond_b,
  output logic [AW-1:0] pc,
  output logic          pmem_re,
  output logic [DW-1:0] dmem_addr,
  output logic          dmem_we,
  output logic          dmem_re,
  output logic          ovf,
  output logic          unf,
  output logic          halted
);
  import psq_pkg::*;

  psq_op_e       kind;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] pc_n;
  logic [AW-1:0] pc_inc;
  logic          ovf_q;
  logic          unf_q;
  logic          active;

  // Named internal events for the checker.
  logic          br_taken;
  logic          stk_push;
  logic          stk_pop;
  logic          stk_dec;
  logic          stk_full;
  logic          stk_empty;
  logic [AW-1:0] stk_top_addr;
  logic [CW-1:0] stk_top_cnt;
  logic [CW-1:0] push_cnt;
  logic          set_ovf;
  logic          set_unf;

  assign kind   = psq_op_e'(op);
  assign halted = ovf_q | unf_q;
  assign active = ~stall & ~halted;
  assign pc_inc = pc_q + AW'(1);

  psq_cond_unit u_cond (
    .mode   (br_mode),
    .cond_a (cond_a),
    .cond_b (cond_b),
    .taken  (br_taken)
  );

  always_comb begin
    pc_n     = pc_q;
    stk_push = 1'b0;
    stk_pop  = 1'b0;
    stk_dec  = 1'b0;
    push_cnt = '0;
    set_ovf  = 1'b0;
    set_unf  = 1'b0;
    if (active) begin
      if (op_pushes(kind, br_taken)) begin
        if (stk_full) begin
          set_ovf = 1'b1;
        end else begin
          stk_push = 1'b1;
          if (kind == OP_LOOP) begin
            push_cnt = count;
            pc_n     = pc_inc;
          end else begin
            pc_n = target;
          end
        end
      end else if (op_pops(kind)) begin
        if (stk_empty) begin
          set_unf = 1'b1;
        end else if (kind == OP_RETURN) begin
          stk_pop = 1'b1;
          pc_n    = stk_top_addr;
        end else if (loop_again(int'(stk_top_cnt))) begin
          stk_dec = 1'b1;
          pc_n    = stk_top_addr;
        end else begin
          stk_pop = 1'b1;
          pc_n    = pc_inc;
        end
      end else begin
        pc_n = pc_inc;
      end
    end
  end

  psq_stack #(
    .DEPTH (DEPTH),
    .AW    (AW),
    .CW    (CW)
  ) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (stk_push),
    .push_addr (pc_inc),
    .push_cnt  (push_cnt),
    .pop       (stk_pop),
    .dec_top   (stk_dec),
    .top_addr  (stk_top_addr),
    .top_cnt   (stk_top_cnt),
    .full      (stk_full),
    .empty     (stk_empty)
  );

  psq_data_port #(
    .DW (DW)
  ) u_data (
    .active    (active),
    .op        (op),
    .operand   (operand),
    .dmem_addr (dmem_addr),
    .dmem_we   (dmem_we),
    .dmem_re   (dmem_re)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      pc_q  <= pc_n;
      ovf_q <= ovf_q | set_ovf;
      unf_q <= unf_q | set_unf;
    end
  end

  assign pc      = pc_q;
  assign pmem_re = ~halted;
  assign ovf     = ovf_q;
  assign unf     = unf_q;

endmodule

// File: rtl/psq_sequencer_chk.sv
module psq_sequencer_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic [2:0]    op,
  input logic [AW-1:0] target,
  input logic [AW-1:0] pc,
  input logic          dmem_we,
  input logic          dmem_re,
  input logic          ovf,
  input logic          unf,
  input logic          halted,
  input logic          br_taken,
  input logic          stk_full,
  input logic          stk_empty
);
  logic run;
  assign run = !stall && !halted;

  a_r2_decode_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (op == 3'd0 || op == 3'd1)) |-> (dmem_we && !dmem_re));

  a_r3_calc_read_write: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == 3'd3) |-> (dmem_we && dmem_re));

  a_r4_call_jumps: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == 3'd2 && !stk_full) |=> (pc == $past(target)));

  a_r6_untaken_falls_through: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == 3'd5 && !br_taken) |=> (pc == AW'($past(pc) + AW'(1))));

  a_r7_empty_return_underflows: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == 3'd7 && stk_empty) |=> unf);

  a_r7_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unf |=> unf);

  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  a_r8_full_call_overflows: assert property (@(posedge clk) disable iff (!rst_n)
    (run && op == 3'd2 && stk_full) |=> (ovf && $stable(pc)));

  a_r9_stall_freezes_pc: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(pc));

  a_r9_stall_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!dmem_we && !dmem_re));

  a_r10_halt_blocks_access: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!dmem_we && !dmem_re));

  a_r10_halt_freezes_pc: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(pc));

endmodule

bind psq_sequencer psq_sequencer_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stall     (stall),
  .op        (op),
  .target    (target),
  .pc        (pc),
  .dmem_we   (dmem_we),
  .dmem_re   (dmem_re),
  .ovf       (ovf),
  .unf       (unf),
  .halted    (halted),
  .br_taken  (br_taken),
  .stk_full  (stk_full),
  .stk_empty (stk_empty)
);

// File: tb/psq_sequencer_bench.sv
module psq_sequencer_bench;
  localparam int AW = 10;
  localparam int CW = 8;
  localparam int DW = 8;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall = 1'b0;
  logic [2:0]    op = '0;
  logic [AW-1:0] target = '0;
  logic [CW-1:0] count = '0;
  logic [DW-1:0] operand = '0;
  logic [1:0]    br_mode = '0;
  logic          cond_a = 1'b0;
  logic          cond_b = 1'b0;
  logic [AW-1:0] pc;
  logic          pmem_re;
  logic [DW-1:0] dmem_addr;
  logic          dmem_we;
  logic          dmem_re;
  logic          ovf;
  logic          unf;
  logic          halted;

  psq_sequencer #(.AW(AW), .CW(CW), .DW(DW), .DEPTH(DEPTH)) u_psq_sequencer (
    .clk(clk), .rst_n(rst_n), .stall(stall), .op(op), .target(target),
    .count(count), .operand(operand), .br_mode(br_mode), .cond_a(cond_a),
    .cond_b(cond_b), .pc(pc), .pmem_re(pmem_re), .dmem_addr(dmem_addr),
    .dmem_we(dmem_we), .dmem_re(dmem_re), .ovf(ovf), .unf(unf), .halted(halted)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state kept by the bench.
  int m_pc;
  int m_sp;
  int m_ret [DEPTH];
  int m_cnt [DEPTH];
  bit m_ovf;
  bit m_unf;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit m_cond(input int mode, input bit a, input bit b);
    if (mode >= 2) return a;
    if (mode == 1) return a || b;
    return a && b;
  endfunction

  function automatic int wrap(input int v);
    return v % (1 << AW);
  endfunction

  task automatic m_reset();
    m_pc = 0; m_sp = 0; m_ovf = 0; m_unf = 0;
  endtask

  task automatic m_push(input int ra, input int c, input int next_pc);
    if (m_sp == DEPTH) begin
      m_ovf = 1;
    end else begin
      m_ret[m_sp] = ra; m_cnt[m_sp] = c; m_sp++;
      m_pc = next_pc;
    end
  endtask

  task automatic m_apply(input int o, input int t, input int c, input int md,
                         input bit a, input bit b, input bit st);
    int nxt;
    nxt = wrap(m_pc + 1);
    if (st || m_ovf || m_unf) return;
    case (o)
      2: m_push(nxt, 0, t);
      4: m_push(nxt, c, nxt);
      5: if (m_cond(md, a, b)) m_push(nxt, 0, t); else m_pc = nxt;
      6: begin
        if (m_sp == 0) m_unf = 1;
        else if (m_cnt[m_sp-1] >= 2) begin
          m_cnt[m_sp-1]--; m_pc = m_ret[m_sp-1];
        end else begin
          m_sp--; m_pc = nxt;
        end
      end
      7: begin
        if (m_sp == 0) m_unf = 1;
        else begin m_sp--; m_pc = m_ret[m_sp]; end
      end
      default: m_pc = nxt;
    endcase
  endtask

  task automatic do_reset();
    rst_n = 1'b0; stall = 1'b0; op = '0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    m_reset();
    #1;
    chk("R1", "pc", int'(pc), 0);
    chk("R1", "halted", int'(halted), 0);
    chk("R1", "ovf", int'(ovf), 0);
    chk("R1", "unf", int'(unf), 0);
  endtask

  task automatic step(input string tag, input int o, input int t, input int c,
                      input int opd, input int md, input bit a, input bit b, input bit st);
    bit live;
    bit exp_we;
    op = 3'(o); target = AW'(t); count = CW'(c); operand = DW'(opd);
    br_mode = 2'(md); cond_a = a; cond_b = b; stall = st;
    #1;
    live = !st && !m_ovf && !m_unf;
    exp_we = live && (o == 0 || o == 1 || o == 3);
    chk(tag, "dmem_we", int'(dmem_we), int'(exp_we));
    chk(tag, "dmem_re", int'(dmem_re), int'(live && o == 3));
    if (exp_we) chk(tag, "dmem_addr", int'(dmem_addr), opd);
    chk(tag, "pmem_re", int'(pmem_re), int'(!m_ovf && !m_unf));
    m_apply(o, t, c, md, a, b, st);
    @(posedge clk);
    #1;
    chk(tag, "pc", int'(pc), m_pc);
    chk(tag, "ovf", int'(ovf), int'(m_ovf));
    chk(tag, "unf", int'(unf), int'(m_unf));
    chk(tag, "halted", int'(halted), int'(m_ovf || m_unf));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    do_reset();

    // R2 / R3: straight-line decode and calculate
    step("R2", 0, 0, 0, 8'h12, 0, 0, 0, 0);
    step("R2", 1, 0, 0, 8'h34, 0, 0, 0, 0);
    step("R3", 3, 0, 0, 8'h12, 0, 0, 0, 0);
    // R4: call and return
    step("R4", 2, 100, 0, 0, 0, 0, 0, 0);
    chk("R4", "call target", int'(pc), 100);
    step("R4", 0, 0, 0, 8'h05, 0, 0, 0, 0);
    step("R4", 7, 0, 0, 0, 0, 0, 0, 0);
    chk("R4", "return address", int'(pc), 4);
    // R5: loop of three passes
    step("R5", 4, 0, 3, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      step("R5", 0, 0, 0, i, 0, 0, 0, 0);
      step("R5", 6, 0, 0, 0, 0, 0, 0, 0);
    end
    chk("R5", "exit after 3 passes", int'(pc), 7);
    // R5: count 0 runs once
    step("R5", 4, 0, 0, 0, 0, 0, 0, 0);
    step("R5", 1, 0, 0, 8'h40, 0, 0, 0, 0);
    step("R5", 6, 0, 0, 0, 0, 0, 0, 0);
    chk("R5", "count 0 exit", int'(pc), 10);
    // R6: branch modes
    step("R6", 5, 200, 0, 0, 0, 1, 0, 0);
    chk("R6", "and untaken", int'(pc), 11);
    step("R6", 5, 200, 0, 0, 0, 1, 1, 0);
    chk("R6", "and taken", int'(pc), 200);
    step("R6", 7, 0, 0, 0, 0, 0, 0, 0);
    step("R6", 5, 300, 0, 0, 1, 0, 1, 0);
    chk("R6", "or taken", int'(pc), 300);
    step("R6", 7, 0, 0, 0, 0, 0, 0, 0);
    step("R6", 5, 400, 0, 0, 2, 0, 1, 0);
    step("R6", 5, 410, 0, 0, 3, 1, 0, 0);
    chk("R6", "first-only taken", int'(pc), 410);
    step("R6", 7, 0, 0, 0, 0, 0, 0, 0);
    // R9: stall holds everything
    step("R9", 2, 50, 0, 0, 0, 0, 0, 1);
    step("R9", 0, 0, 0, 8'h77, 0, 0, 0, 1);
    step("R9", 3, 0, 0, 8'h77, 0, 0, 0, 1);
    // R7: empty return underflows (also shows no push from untaken/stalled)
    step("R7", 7, 0, 0, 0, 0, 0, 0, 0);
    chk("R7", "underflow", int'(unf), 1);
    // R10: halted stays frozen
    step("R10", 0, 0, 0, 8'h11, 0, 0, 0, 0);
    step("R10", 2, 90, 0, 0, 0, 0, 0, 0);
    do_reset();
    // R8: fill and overflow
    for (int i = 0; i < DEPTH; i++) step("R8", 2, 20 + i * 3, 0, 0, 0, 0, 0, 0);
    step("R8", 4, 0, 2, 0, 0, 0, 0, 0);
    chk("R8", "overflow", int'(ovf), 1);
    step("R10", 3, 0, 0, 8'h22, 0, 0, 0, 0);
    do_reset();
    step("R7", 6, 0, 0, 0, 0, 0, 0, 0);
    chk("R7", "endloop underflow", int'(unf), 1);
    do_reset();

    // Constrained random mix
    for (int n = 0; n < 4000; n++) begin
      int o;
      if (m_ovf || m_unf) begin
        if ($urandom_range(3) == 0) do_reset();
      end
      o = int'($urandom_range(7));
      step("R2-mix", o, int'($urandom_range((1 << AW) - 1)), int'($urandom_range(3)),
           int'($urandom_range(255)), int'($urandom_range(3)),
           bit'($urandom_range(1)), bit'($urandom_range(1)),
           bit'($urandom_range(7) == 0));
    end

    finish_run();
  end
endmodule